// File: doc/BRIEF.md
# Conditional Branch Resolver

This block decides the outcome of a conditional branch for an instruction pipeline. Each request carries a four-bit condition code, an annul flag, a signed 22-bit word displacement, the address of the branch and the address of its delay slot. It also carries the integer flags (negative, zero, overflow, carry) and a two-bit floating compare code. A mode input selects whether the condition is tested against the integer flags or against the floating compare code. One clock later the block returns whether the branch is taken and whether the delay-slot instruction is squashed. It also returns the branch target, the next fetch address, and a flag that marks a floating branch issued while the floating unit is switched off.

The low three condition bits pick one of eight base tests. The top bit turns the chosen test into its complement, so one small table serves all sixteen codes in each mode. Integer and floating branches use the same target adder. The unconditional code with its annul flag set is handled specially: the branch is taken and its delay slot is still squashed.

Top module: `brcond_eval`

## Requirements
- R1: `res_vld` is high exactly one clock after a cycle with `req_vld` high and low after a cycle with `req_vld` low. While `rst_n` is low every output is 0.
- R2: `cond[2:0]` selects a base test and `cond[3]` = 1 returns its complement. Base 0 is false, so code 4'b0000 is never taken and code 4'b1000 is always taken.
- R3: In integer mode (`req_fmode` = 0) the base tests for `cond[2:0]` = 1..7 are: Z; Z or (N xor V); N xor V; C or Z; C; N; V.
- R4: In float mode (`req_fmode` = 1) the compare code is 0 = equal, 1 = less, 2 = greater, 3 = unordered. The base tests for `cond[2:0]` = 1..7 are: not equal; less or greater; less or unordered; less; greater or unordered; greater; unordered.
- R5: `res_target` = `pc` + (sign-extended `disp` shifted left by two), wrapping modulo 2^32. It is produced for every request, taken or not.
- R6: `res_next` equals `res_target` when the branch is taken and `npc` + 4 (modulo 2^32) otherwise.
- R7: Code 4'b1000 with `annul_bit` = 1 gives `res_taken` = 1 and `res_annul` = 1. With `annul_bit` = 0 it gives `res_annul` = 0.
- R8: For every other code, `res_annul` = `annul_bit` AND NOT `res_taken`. A taken conditional branch never squashes its delay slot.
- R9: A float-mode request with `fpu_en` = 0 gives `res_fp_off` = 1, `res_taken` = 0, `res_annul` = 0 and `res_next` = `npc` + 4. In integer mode `res_fp_off` = 0 whatever `fpu_en` is.
- R10: Integer mode ignores `fcc`, and float mode ignores the four integer flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | 1 | Request present this cycle |
| req_fmode | input | 1 | 1 = test float compare code, 0 = test integer flags |
| fpu_en | input | 1 | Floating unit enabled |
| cond | input | 4 | Condition code of the branch |
| annul_bit | input | 1 | Annul flag of the branch |
| disp | input | 22 | Signed word displacement |
| pc | input | 32 | Address of the branch |
| npc | input | 32 | Address of the delay slot |
| flag_n | input | 1 | Integer negative flag |
| flag_z | input | 1 | Integer zero flag |
| flag_v | input | 1 | Integer overflow flag |
| flag_c | input | 1 | Integer carry flag |
| fcc | input | 2 | Floating compare code |
| res_vld | output | 1 | Result valid |
| res_taken | output | 1 | Branch taken |
| res_annul | output | 1 | Delay slot squashed |
| res_fp_off | output | 1 | Float branch issued with floating unit off |
| res_target | output | 32 | Branch target address |
| res_next | output | 32 | Next fetch address |

## Verification
All results of a request come out together, one rising edge after the request is presented, with no stall or reordering. The bench drives each request just after a falling edge and records its expected result in a queue at the same moment. At each later falling edge, when `res_vld` is high, it takes the oldest entry and compares it with the outputs. A result that arrives a cycle early or late, or for a bubble cycle, therefore reaches the compare out of step with the queue, and the final emptiness and count checks expose any lost or extra result.

// File: rtl/brc_pkg.sv
package brc_pkg;

  typedef enum logic [1:0] {
    FCC_EQ = 2'd0,
    FCC_LT = 2'd1,
    FCC_GT = 2'd2,
    FCC_UN = 2'd3
  } fcc_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } icc_t;

  localparam logic [3:0] COND_ALWAYS = 4'b1000;

endpackage

// File: rtl/brc_int_pred.sv
module brc_int_pred
  import brc_pkg::*;
(
  input  icc_t       icc,
  input  logic [2:0] sel,
  output logic       hit
);

  always_comb begin
    case (sel)
      3'd0:    hit = 1'b0;
      3'd1:    hit = icc.z;
      3'd2:    hit = icc.z | (icc.n ^ icc.v);
      3'd3:    hit = icc.n ^ icc.v;
      3'd4:    hit = icc.c | icc.z;
      3'd5:    hit = icc.c;
      3'd6:    hit = icc.n;
      default: hit = icc.v;
    endcase
  end

endmodule

// File: rtl/brc_fp_pred.sv
module brc_fp_pred
  import brc_pkg::*;
(
  input  logic [1:0] fcc,
  input  logic [2:0] sel,
  output logic       hit
);

  fcc_e code;
  logic is_eq, is_lt, is_gt, is_un;

  always_comb begin
    code  = fcc_e'(fcc);
    is_eq = (code == FCC_EQ);
    is_lt = (code == FCC_LT);
    is_gt = (code == FCC_GT);
    is_un = (code == FCC_UN);
    case (sel)
      3'd0:    hit = 1'b0;
      3'd1:    hit = ~is_eq;
      3'd2:    hit = is_lt | is_gt;
      3'd3:    hit = is_lt | is_un;
      3'd4:    hit = is_lt;
      3'd5:    hit = is_gt | is_un;
      3'd6:    hit = is_gt;
      default: hit = is_un;
    endcase
  end

endmodule

// File: rtl/brc_target.sv
module brc_target #(
  parameter int AW = 32,
  parameter int DW = 22
) (
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] npc,
  input  logic [DW-1:0] disp,
  output logic [AW-1:0] target,
  output logic [AW-1:0] seq
);

  localparam int EXT_W = AW - DW - 2;
  localparam logic [AW-1:0] STEP = AW'(4);

  logic [AW-1:0] offset;

  always_comb begin
    offset = {{EXT_W{disp[DW-1]}}, disp, 2'b00};
    target = pc + offset;
    seq    = npc + STEP;
  end

endmodule

// File: rtl/brcond_eval.sv
module brcond_eval
  import brc_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 22
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_vld,
  input  logic          req_fmode,
  input  logic          fpu_en,
  input  logic [3:0]    cond,
  input  logic          annul_bit,
  input  logic [DW-1:0] disp,
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] npc,
  input  logic          flag_n,
  input  logic          flag_z,
  input  logic          flag_v,
  input  logic          flag_c,
  input  logic [1:0]    fcc,
  output logic          res_vld,
  output logic          res_taken,
  output logic          res_annul,
  output logic          res_fp_off,
  output logic [AW-1:0] res_target,
  output logic [AW-1:0] res_next
);

  icc_t          icc;
  logic          int_hit, fp_hit, base_hit, pred;
  logic          is_always, fp_off_d, taken_d, annul_d;
  logic [AW-1:0] tgt_d, seq_d, next_d;

  always_comb begin
    icc.n = flag_n;
    icc.z = flag_z;
    icc.v = flag_v;
    icc.c = flag_c;
  end

  brc_int_pred u_int (
    .icc (icc),
    .sel (cond[2:0]),
    .hit (int_hit)
  );

  brc_fp_pred u_fp (
    .fcc (fcc),
    .sel (cond[2:0]),
    .hit (fp_hit)
  );

  brc_target #(.AW(AW), .DW(DW)) u_tgt (
    .pc     (pc),
    .npc    (npc),
    .disp   (disp),
    .target (tgt_d),
    .seq    (seq_d)
  );

  // next-state decision
  always_comb begin
    base_hit  = req_fmode ? fp_hit : int_hit;
    pred      = base_hit ^ cond[3];
    is_always = (cond == COND_ALWAYS);
    fp_off_d  = req_fmode & ~fpu_en;
    taken_d   = pred & ~fp_off_d;
    annul_d   = annul_bit & ~fp_off_d & (is_always | ~taken_d);
    next_d    = taken_d ? tgt_d : seq_d;
  end

  // valid flag: loads every cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_vld <= 1'b0;
    end else begin
      res_vld <= req_vld;
    end
  end

  // result registers: enabled by an accepted request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_taken  <= 1'b0;
      res_annul  <= 1'b0;
      res_fp_off <= 1'b0;
      res_target <= '0;
      res_next   <= '0;
    end else if (req_vld) begin
      res_taken  <= taken_d;
      res_annul  <= annul_d;
      res_fp_off <= fp_off_d;
      res_target <= tgt_d;
      res_next   <= next_d;
    end
  end

endmodule

// File: rtl/brcond_eval_chk.sv
module brcond_eval_chk #(
  parameter int AW = 32,
  parameter int DW = 22
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_vld,
  input logic          req_fmode,
  input logic          fpu_en,
  input logic [3:0]    cond,
  input logic          annul_bit,
  input logic [AW-1:0] npc,
  input logic          res_vld,
  input logic          res_taken,
  input logic          res_annul,
  input logic          res_fp_off,
  input logic [AW-1:0] res_target,
  input logic [AW-1:0] res_next
);

  // R1
  vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |=> res_vld);

  // R1
  vld_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld |=> !res_vld);

  // R2
  never_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && cond == 4'b0000) |=> !res_taken);

  // R6
  seq_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && !res_taken) |-> (res_next == $past(npc) + AW'(4)));

  // R6
  tkn_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && res_taken) |-> (res_next == res_target));

  // R7
  ba_annul_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && cond == 4'b1000 && annul_bit && !(req_fmode && !fpu_en))
      |=> (res_taken && res_annul));

  // R8
  cond_annul_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && !res_fp_off && $past(cond) != 4'b1000)
      |-> (res_annul == ($past(annul_bit) && !res_taken)));

  // R9
  fpoff_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |=> (res_fp_off == $past(req_fmode && !fpu_en)));

  // R9
  fpoff_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && res_fp_off) |-> (!res_taken && !res_annul));

endmodule

bind brcond_eval brcond_eval_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_vld    (req_vld),
  .req_fmode  (req_fmode),
  .fpu_en     (fpu_en),
  .cond       (cond),
  .annul_bit  (annul_bit),
  .npc        (npc),
  .res_vld    (res_vld),
  .res_taken  (res_taken),
  .res_annul  (res_annul),
  .res_fp_off (res_fp_off),
  .res_target (res_target),
  .res_next   (res_next)
);

// File: tb/sim_brcond_eval.sv
module sim_brcond_eval;

  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n;
  logic        req_vld, req_fmode, fpu_en, annul_bit;
  logic [3:0]  cond;
  logic [21:0] disp;
  logic [31:0] pc, npc;
  logic        flag_n, flag_z, flag_v, flag_c;
  logic [1:0]  fcc;
  logic        res_vld, res_taken, res_annul, res_fp_off;
  logic [31:0] res_target, res_next;

  int checks = 0;
  int fails  = 0;
  int sent   = 0;
  int seen   = 0;

  typedef struct {
    logic        fm;
    logic [3:0]  cd;
    logic        tk;
    logic        an;
    logic        fo;
    logic [31:0] tg;
    logic [31:0] nx;
  } exp_t;

  exp_t sb[$];

  brcond_eval u0 (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_fmode(req_fmode),
    .fpu_en(fpu_en), .cond(cond), .annul_bit(annul_bit), .disp(disp),
    .pc(pc), .npc(npc), .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v),
    .flag_c(flag_c), .fcc(fcc), .res_vld(res_vld), .res_taken(res_taken),
    .res_annul(res_annul), .res_fp_off(res_fp_off), .res_target(res_target),
    .res_next(res_next)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // reference tables taken from R3 and R4
  function automatic logic ref_int(input logic [2:0] s, input logic n,
                                   input logic z, input logic v, input logic c);
    case (s)
      3'd0: return 1'b0;
      3'd1: return z;
      3'd2: return z | (n ^ v);
      3'd3: return n ^ v;
      3'd4: return c | z;
      3'd5: return c;
      3'd6: return n;
      default: return v;
    endcase
  endfunction

  function automatic logic ref_fp(input logic [2:0] s, input logic [1:0] f);
    logic e, l, g, u;
    e = (f == 2'd0); l = (f == 2'd1); g = (f == 2'd2); u = (f == 2'd3);
    case (s)
      3'd0: return 1'b0;
      3'd1: return !e;
      3'd2: return l | g;
      3'd3: return l | u;
      3'd4: return l;
      3'd5: return g | u;
      3'd6: return g;
      default: return u;
    endcase
  endfunction

  task automatic send(input logic fm, input logic fe, input logic [3:0] cd,
                      input logic an, input logic [21:0] dp,
                      input logic [31:0] p, input logic [31:0] np,
                      input logic [3:0] nzvc, input logic [1:0] fc);
    exp_t e;
    logic base, off;
    @(negedge clk);
    req_vld = 1'b1; req_fmode = fm; fpu_en = fe; cond = cd; annul_bit = an;
    disp = dp; pc = p; npc = np;
    {flag_n, flag_z, flag_v, flag_c} = nzvc; fcc = fc;
    base = fm ? ref_fp(cd[2:0], fc)
              : ref_int(cd[2:0], nzvc[3], nzvc[2], nzvc[1], nzvc[0]);
    off  = fm && !fe;
    e.fm = fm;
    e.cd = cd;
    e.fo = off;
    e.tk = (base ^ cd[3]) && !off;
    e.an = off ? 1'b0 : ((cd == 4'b1000) ? an : (an && !e.tk));
    e.tg = p + {{8{dp[21]}}, dp, 2'b00};
    e.nx = e.tk ? e.tg : np + 32'd4;
    sb.push_back(e);
    sent++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_vld = 1'b0;
    end
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && res_vld) begin
        seen++;
        if (sb.size() == 0) begin
          checks++; fails++;
          $display("FAIL R1 unexpected result actual=1 expected=0");
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(e.fm ? "R4" : "R3", $sformatf("taken cond=%h", e.cd),
                32'(res_taken), 32'(e.tk));
          check(e.cd == 4'b1000 ? "R7" : "R8", $sformatf("annul cond=%h", e.cd),
                32'(res_annul), 32'(e.an));
          check("R9", "fp_off", 32'(res_fp_off), 32'(e.fo));
          check("R5", "target", res_target, e.tg);
          check("R6", "next", res_next, e.nx);
        end
      end
    end
  end

  // watchdog
  initial begin
    #(CLK_PERIOD * 100000);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_vld = 1'b0; req_fmode = 1'b0; fpu_en = 1'b0;
    cond = '0; annul_bit = 1'b0; disp = '0; pc = '0; npc = '0;
    flag_n = 1'b0; flag_z = 1'b0; flag_v = 1'b0; flag_c = 1'b0; fcc = '0;
    repeat (3) @(negedge clk);
    req_vld = 1'b1; cond = 4'b1000;
    @(negedge clk);
    // R1 reset state
    check("R1", "reset vld", 32'(res_vld), 32'd0);
    check("R1", "reset taken", 32'(res_taken), 32'd0);
    check("R1", "reset next", res_next, 32'd0);
    req_vld = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "vld after release", 32'(res_vld), 32'd0);

    // R2 R3 R10: integer sweep, fcc and fpu_en vary but must not matter
    for (int c = 0; c < 16; c++)
      for (int f = 0; f < 16; f++)
        for (int a = 0; a < 2; a++)
          send(1'b0, 1'(f), 4'(c), 1'(a), 22'(c * 4099 + f * 131 + a * 7),
               32'h4000_0000 + 32'(c * 256 + f * 8), 32'h4000_0004 + 32'(c * 256 + f * 8),
               4'(f), 2'(c + f));

    // R4 R10: float sweep with integer flags varying
    for (int c = 0; c < 16; c++)
      for (int f = 0; f < 4; f++)
        for (int a = 0; a < 2; a++)
          send(1'b1, 1'b1, 4'(c), 1'(a), 22'(22'h3F0000 + c * 37 + f),
               32'h0001_0000 + 32'(c * 16), 32'h0001_0004 + 32'(c * 16),
               4'(c * 3 + f), 2'(f));

    // R9: float request with unit switched off
    for (int c = 0; c < 16; c++)
      send(1'b1, 1'b0, 4'(c), 1'(c), 22'h000010, 32'h0000_2000,
           32'h0000_2004, 4'hF, 2'(c));

    idle(2);
    // R1: bubbles produce nothing
    check("R1", "bubble vld", 32'(res_vld), 32'd0);

    // R5 R6: displacement and wrap corners, always taken
    send(1'b0, 1'b1, 4'b1000, 1'b0, 22'h1FFFFF, 32'h0000_0100, 32'h0000_0104, 4'h0, 2'd0);
    send(1'b0, 1'b1, 4'b1000, 1'b0, 22'h200000, 32'h0100_0000, 32'h0100_0004, 4'h0, 2'd0);
    send(1'b0, 1'b1, 4'b1000, 1'b1, 22'h3FFFFF, 32'h0000_0000, 32'h0000_0004, 4'h0, 2'd0);
    send(1'b0, 1'b1, 4'b1000, 1'b0, 22'h000004, 32'hFFFF_FFF0, 32'hFFFF_FFF4, 4'h0, 2'd0);
    // R6: sequential wrap when not taken
    send(1'b0, 1'b1, 4'b0000, 1'b1, 22'h000004, 32'hFFFF_FFF8, 32'hFFFF_FFFC, 4'h0, 2'd0);
    send(1'b1, 1'b1, 4'b0000, 1'b0, 22'h2AAAAA, 32'h1234_5678, 32'h1234_567C, 4'hA, 2'd3);

    idle(4);
    // R1: every request produced exactly one result
    check("R1", "result count", 32'(seen), 32'(sent));
    check("R1", "queue empty", 32'(sb.size()), 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule